// File: doc/BRIEF.md
# Multi-Channel PWM Generator with Fault Gating

This block drives several pulse-width-modulated outputs from one shared timebase. A prescaler divides the clock by 1, 2, 4 or 8. A counter then runs from zero up to a programmable modulus minus one, so each period lasts modulus × prescale clocks. Each channel has its own compare value. Its output is high while the counter is below that value.

An external fault input can force chosen channels low. A mask register, which software can set only once after reset, picks which channels are cut off when the fault input is asserted. A fault control register does three things:
- it selects automatic or manual recovery;
- it enables or masks the interrupt;
- it accepts a flag-clear command.

New modulus, prescale and compare values wait in shadow registers. They move into the live registers only at a period boundary, so a period is never cut short or stretched by a write.

Top module: `pwm_fault_gate`

## Requirements
- R1: The prescale field (address 1, bits [1:0]) selects a divide factor of 2^field, so 00 gives 1, 01 gives 2, 10 gives 4 and 11 gives 8. The period in clocks equals modulus (address 0) × factor. A modulus of 0 acts as 1.
- R2: Channel i (compare at address 4+i) is high for min(compare, modulus) × factor clocks per period. A compare of 0 keeps it low, and a compare at or above the modulus keeps it high.
- R3: Writes to modulus, prescale and compare go to shadow registers. They take effect only at the next period boundary, so the period that is running completes with its old length.
- R4: Only the first write after reset to the disable mask (address 3, bit i for channel i) is stored. Any later write leaves the mask unchanged until the next reset.
- R5: While the fault input is high, every channel whose mask bit is 1 reads 0 in the same cycle. Channels whose mask bit is 0 keep their normal waveform.
- R6: The fault flag output goes to 1 on the clock after the fault input is seen high. The interrupt output equals the flag ANDed with the interrupt enable (fault control bit 1).
- R7: In automatic recovery (fault control bit 0 = 0), the flag clears and the masked channels resume at the first period boundary at which the fault input is low.
- R8: In manual recovery (fault control bit 0 = 1), the flag clears only when a fault control write has bit 2 set while the fault input is low. Masked channels resume at the first period boundary after the flag has cleared.
- R9: After reset the outputs are low, the flag and the interrupt are 0, the modulus is 1, the factor is 1, all compares and the mask are 0, recovery is automatic and the interrupt is disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register address |
| wr_data | input | CW | Register write data |
| fault_i | input | 1 | External fault, active high |
| pwm_o | output | NCH | PWM outputs |
| fault_flag_o | output | 1 | Fault status flag |
| irq_o | output | 1 | Fault interrupt request |

## Verification
The assertions assume the fault input is synchronous to the clock and that a register write lasts exactly one cycle. The bench drives every input on the falling edge, so both assumptions hold.

The hold properties for the gate and the manual flag assume that only the fault input and a qualified clear write can move that state. The stimulus therefore changes the recovery mode only while no fault is pending. The bench also writes the mask once and then attempts a second, conflicting write.

// File: rtl/pwmfg_pkg.sv
package pwmfg_pkg;

   // register addresses
   localparam int unsigned ADR_MOD  = 0;
   localparam int unsigned ADR_PRE  = 1;
   localparam int unsigned ADR_FCTL = 2;
   localparam int unsigned ADR_MAP  = 3;
   localparam int unsigned ADR_CMP0 = 4;

   // fault control bit positions
   localparam int unsigned FCTL_MANUAL = 0;
   localparam int unsigned FCTL_IRQEN  = 1;
   localparam int unsigned FCTL_CLEAR  = 2;
   localparam int unsigned FCTL_W      = 3;

   typedef enum logic {
      REC_AUTO   = 1'b0,
      REC_MANUAL = 1'b1
   } rec_mode_e;

endpackage

// File: rtl/pwmfg_timebase.sv
module pwmfg_timebase #(
   parameter int CW    = 8,
   parameter int PRE_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CW-1:0]    mod_sh,
   input  logic [PRE_W-1:0] pre_sh,
   output logic [CW-1:0]    cnt_q,
   output logic [CW-1:0]    mod_act,
   output logic             bnd
);

   localparam int PCW = (1 << PRE_W) - 1;

   logic [PRE_W-1:0] pre_act;
   logic [PCW-1:0]   pcnt_q;
   logic [PCW:0]     pf_m1;
   logic [CW-1:0]    mod_eff;
   logic             tick;
   logic             wrap;

   always_comb begin
      pf_m1   = ((PCW+1)'(1) << pre_act) - (PCW+1)'(1);
      tick    = (pcnt_q == pf_m1[PCW-1:0]);
      mod_eff = (mod_act == '0) ? CW'(1) : mod_act;
      wrap    = (cnt_q == mod_eff - CW'(1));
      bnd     = tick && wrap;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pcnt_q  <= '0;
         cnt_q   <= '0;
         mod_act <= CW'(1);
         pre_act <= '0;
      end else if (bnd) begin
         pcnt_q  <= '0;
         cnt_q   <= '0;
         mod_act <= mod_sh;
         pre_act <= pre_sh;
      end else if (tick) begin
         pcnt_q  <= '0;
         cnt_q   <= cnt_q + CW'(1);
      end else begin
         pcnt_q  <= pcnt_q + PCW'(1);
      end
   end

endmodule

// File: rtl/pwmfg_chan.sv
module pwmfg_chan #(
   parameter int CW      = 8,
   parameter bit OUT_REG = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bnd,
   input  logic [CW-1:0] cnt,
   input  logic [CW-1:0] cmp_sh,
   input  logic          kill,
   output logic          pwm
);

   logic [CW-1:0] cmp_act;
   logic          level;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cmp_act <= '0;
      else if (bnd) cmp_act <= cmp_sh;
   end

   generate
      if (OUT_REG) begin : g_reg
         logic lvl_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) lvl_q <= 1'b0;
            else        lvl_q <= (cnt < cmp_act);
         end
         assign level = lvl_q;
      end else begin : g_comb
         assign level = (cnt < cmp_act);
      end
   endgenerate

   assign pwm = level & ~kill;

endmodule

// File: rtl/pwmfg_fault.sv
module pwmfg_fault
   import pwmfg_pkg::*;
#(
   parameter int NCH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fault_i,
   input  logic              bnd,
   input  logic              map_we,
   input  logic [NCH-1:0]    map_wd,
   input  logic              ctl_we,
   input  logic [FCTL_W-1:0] ctl_wd,
   output logic [NCH-1:0]    kill,
   output logic              flag_o,
   output logic              irq_o,
   output logic [NCH-1:0]    map_q,
   output logic              map_lock,
   output logic              gated_q,
   output logic              manual_q,
   output logic              irqen_q,
   output logic              clr_req
);

   rec_mode_e mode_q;
   logic      flag_q;

   assign manual_q = (mode_q == REC_MANUAL);
   assign clr_req  = ctl_we && ctl_wd[FCTL_CLEAR] && manual_q;

   // disable mask: first write after reset sticks
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         map_q    <= '0;
         map_lock <= 1'b0;
      end else if (map_we && !map_lock) begin
         map_q    <= map_wd;
         map_lock <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= REC_AUTO;
         irqen_q <= 1'b0;
      end else if (ctl_we) begin
         mode_q  <= ctl_wd[FCTL_MANUAL] ? REC_MANUAL : REC_AUTO;
         irqen_q <= ctl_wd[FCTL_IRQEN];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
      end else if (fault_i) begin
         flag_q <= 1'b1;
      end else if (manual_q ? clr_req : bnd) begin
         flag_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gated_q <= 1'b0;
      end else if (fault_i) begin
         gated_q <= 1'b1;
      end else if (bnd && (!manual_q || !flag_q)) begin
         gated_q <= 1'b0;
      end
   end

   assign kill   = map_q & {NCH{gated_q | fault_i}};
   assign flag_o = flag_q;
   assign irq_o  = flag_q & irqen_q;

endmodule

// File: rtl/pwm_fault_gate.sv
module pwm_fault_gate
   import pwmfg_pkg::*;
#(
   parameter int NCH     = 4,
   parameter int CW      = 8,
   parameter int PRE_W   = 2,
   parameter int AW      = 4,
   parameter bit OUT_REG = 1'b0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr_en,
   input  logic [AW-1:0]  wr_addr,
   input  logic [CW-1:0]  wr_data,
   input  logic           fault_i,
   output logic [NCH-1:0] pwm_o,
   output logic           fault_flag_o,
   output logic           irq_o
);

   // elaboration-time parameter checks
   generate
      if (NCH < 1 || NCH > CW) begin : g_bad_nch
         $error("NCH must lie in 1..CW");
      end
      if (CW < FCTL_W) begin : g_bad_cw
         $error("CW too narrow for the fault control field");
      end
      if (PRE_W < 1 || PRE_W > 3) begin : g_bad_pre
         $error("PRE_W must lie in 1..3");
      end
      if ((ADR_CMP0 + NCH) > (1 << AW)) begin : g_bad_aw
         $error("AW too narrow for the compare registers");
      end
   endgenerate

   logic             we_mod, we_pre, we_ctl, we_map;
   logic [CW-1:0]    mod_sh;
   logic [PRE_W-1:0] pre_sh;
   logic [CW-1:0]    cnt;
   logic [CW-1:0]    mod_act;
   logic             bnd;
   logic [NCH-1:0]   kill;
   logic [NCH-1:0]   map_q;
   logic             map_lock, gated_q, manual_q, irqen_q, clr_req;

   assign we_mod = wr_en && (wr_addr == AW'(ADR_MOD));
   assign we_pre = wr_en && (wr_addr == AW'(ADR_PRE));
   assign we_ctl = wr_en && (wr_addr == AW'(ADR_FCTL));
   assign we_map = wr_en && (wr_addr == AW'(ADR_MAP));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mod_sh <= CW'(1);
         pre_sh <= '0;
      end else begin
         if (we_mod) mod_sh <= wr_data;
         if (we_pre) pre_sh <= wr_data[PRE_W-1:0];
      end
   end

   pwmfg_timebase #(.CW(CW), .PRE_W(PRE_W)) u_tb (
      .clk     (clk),
      .rst_n   (rst_n),
      .mod_sh  (mod_sh),
      .pre_sh  (pre_sh),
      .cnt_q   (cnt),
      .mod_act (mod_act),
      .bnd     (bnd)
   );

   pwmfg_fault #(.NCH(NCH)) u_flt (
      .clk      (clk),
      .rst_n    (rst_n),
      .fault_i  (fault_i),
      .bnd      (bnd),
      .map_we   (we_map),
      .map_wd   (wr_data[NCH-1:0]),
      .ctl_we   (we_ctl),
      .ctl_wd   (wr_data[FCTL_W-1:0]),
      .kill     (kill),
      .flag_o   (fault_flag_o),
      .irq_o    (irq_o),
      .map_q    (map_q),
      .map_lock (map_lock),
      .gated_q  (gated_q),
      .manual_q (manual_q),
      .irqen_q  (irqen_q),
      .clr_req  (clr_req)
   );

   generate
      for (genvar i = 0; i < NCH; i++) begin : g_ch
         logic          we_cmp;
         logic [CW-1:0] cmp_sh;

         assign we_cmp = wr_en && (wr_addr == AW'(ADR_CMP0 + i));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      cmp_sh <= '0;
            else if (we_cmp) cmp_sh <= wr_data;
         end

         pwmfg_chan #(.CW(CW), .OUT_REG(OUT_REG)) u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .bnd    (bnd),
            .cnt    (cnt),
            .cmp_sh (cmp_sh),
            .kill   (kill[i]),
            .pwm    (pwm_o[i])
         );
      end
   endgenerate

endmodule

// File: rtl/pwmfg_checker.sv
module pwmfg_checker #(
   parameter int NCH = 4,
   parameter int CW  = 8
) (
   input logic           clk,
   input logic           rst_n,
   input logic           fault_i,
   input logic [NCH-1:0] pwm_o,
   input logic           fault_flag_o,
   input logic           irq_o,
   input logic           bnd,
   input logic [CW-1:0]  cnt,
   input logic [CW-1:0]  mod_act,
   input logic [NCH-1:0] map_q,
   input logic           map_lock,
   input logic           gated_q,
   input logic           manual_q,
   input logic           irqen_q,
   input logic           clr_req
);

   p_cnt_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (mod_act == '0) ? (cnt == '0) : (cnt < mod_act));

   p_shadow_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !bnd |=> $stable(mod_act));

   p_map_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
      map_lock |=> $stable(map_q));

   p_fault_kill_r5: assert property (@(posedge clk) disable iff (!rst_n)
      fault_i |-> ((pwm_o & map_q) == '0));

   p_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      fault_i |=> fault_flag_o);

   p_irq_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !irqen_q |-> !irq_o);

   p_gate_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (gated_q && !bnd) |=> gated_q);

   p_manual_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (manual_q && fault_flag_o && !clr_req) |=> fault_flag_o);

endmodule

bind pwm_fault_gate pwmfg_checker #(.NCH(NCH), .CW(CW)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .fault_i      (fault_i),
   .pwm_o        (pwm_o),
   .fault_flag_o (fault_flag_o),
   .irq_o        (irq_o),
   .bnd          (bnd),
   .cnt          (cnt),
   .mod_act      (mod_act),
   .map_q        (map_q),
   .map_lock     (map_lock),
   .gated_q      (gated_q),
   .manual_q     (manual_q),
   .irqen_q      (irqen_q),
   .clr_req      (clr_req)
);

// File: tb/pwm_fault_gate_test.sv
module pwm_fault_gate_test;
   import pwmfg_pkg::*;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [3:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       fault_i = 1'b0;
   logic [3:0] pwm;
   logic       flag, irq;

   int vectors = 0;
   int fails   = 0;
   int m_per;
   int m_hi[4];
   bit m_tmo;

   always #10 clk = ~clk;

   pwm_fault_gate uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en        (wr_en),
      .wr_addr      (wr_addr),
      .wr_data      (wr_data),
      .fault_i      (fault_i),
      .pwm_o        (pwm),
      .fault_flag_o (flag),
      .irq_o        (irq)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_addr = 4'(a);
      wr_data = 8'(d);
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   // returns at the falling edge on which channel 0 has just gone high
   task automatic wait_rise();
      logic prev;
      prev  = pwm[0];
      m_tmo = 1'b0;
      for (int g = 0; g < 3000; g++) begin
         @(negedge clk);
         if (pwm[0] && !prev) return;
         prev = pwm[0];
      end
      m_tmo = 1'b1;
   endtask

   // one period from a rising edge of channel 0 to the next
   task automatic measure();
      logic prev;
      wait_rise();
      m_per = 0;
      for (int c = 0; c < 4; c++) m_hi[c] = 0;
      if (m_tmo) return;
      prev = 1'b0;
      while (m_per < 3000) begin
         for (int c = 0; c < 4; c++) if (pwm[c]) m_hi[c]++;
         m_per++;
         prev = pwm[0];
         @(negedge clk);
         if (pwm[0] && !prev) break;
      end
   endtask

   function automatic int imin(input int a, input int b);
      return (a < b) ? a : b;
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      vectors++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

   initial begin
      int cmpv[4];
      int n;
      logic prev;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R9: reset state
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         chk(pwm == 4'b0000, "R9 outputs", int'(pwm), 0);
      end
      chk(flag == 1'b0, "R9 flag", int'(flag), 0);
      chk(irq == 1'b0, "R9 irq", int'(irq), 0);

      // R1/R2: sweep of prescale and modulus
      for (int p = 0; p < 4; p++) begin
         for (int md = 2; md < 10; md++) begin
            cmpv[0] = 1;
            cmpv[1] = (md % 2 == 0) ? 0 : md / 2;
            cmpv[2] = md - 1;
            cmpv[3] = md + 1;
            wr(ADR_MOD, md);
            wr(ADR_PRE, p);
            for (int c = 0; c < 4; c++) wr(ADR_CMP0 + c, cmpv[c]);
            repeat (160) @(negedge clk);
            measure();
            chk(!m_tmo && m_per == md * (1 << p), "R1 period", m_per, md * (1 << p));
            for (int c = 0; c < 4; c++)
               chk(m_hi[c] == imin(cmpv[c], md) * (1 << p), "R2 high time",
                   m_hi[c], imin(cmpv[c], md) * (1 << p));
         end
      end

      // R3: modulus written mid-period leaves the running period intact
      wr(ADR_MOD, 8);
      wr(ADR_PRE, 3);
      wr(ADR_CMP0, 1);
      repeat (200) @(negedge clk);
      wait_rise();
      n = 0;
      repeat (5) begin @(negedge clk); n++; end
      wr(ADR_MOD, 3);
      n += 2;
      prev = pwm[0];
      while (n < 500) begin
         @(negedge clk);
         n++;
         if (pwm[0] && !prev) break;
         prev = pwm[0];
      end
      chk(n == 64, "R3 old period completes", n, 64);
      measure();
      chk(m_per == 24, "R3 new period", m_per, 24);

      // fault set-up: period 4, all channels high
      wr(ADR_MOD, 4);
      wr(ADR_PRE, 0);
      for (int c = 0; c < 4; c++) wr(ADR_CMP0 + c, 255);
      wr(ADR_MAP, 8'h0C);
      wr(ADR_MAP, 8'h03);
      repeat (20) @(negedge clk);
      chk(pwm == 4'b1111, "R2 compare above modulus", int'(pwm), 15);

      // R5/R4: immediate gating, mask from first write only
      @(negedge clk);
      fault_i = 1'b1;
      #1;
      chk(pwm == 4'b0011, "R5 same-cycle gating / R4 mask", int'(pwm), 3);
      chk(flag == 1'b0, "R6 flag not before clock", int'(flag), 0);
      @(negedge clk);
      chk(flag == 1'b1, "R6 flag set", int'(flag), 1);
      chk(irq == 1'b0, "R6 irq masked", int'(irq), 0);
      repeat (10) @(negedge clk);
      chk(pwm == 4'b0011, "R7 gated while fault high", int'(pwm), 3);
      wr(ADR_FCTL, 2);
      chk(irq == 1'b1, "R6 irq enabled", int'(irq), 1);

      // R7: automatic recovery
      @(negedge clk);
      fault_i = 1'b0;
      #1;
      chk(flag == 1'b1, "R7 flag held to boundary", int'(flag), 1);
      chk(pwm == 4'b0011, "R7 gate held to boundary", int'(pwm), 3);
      repeat (6) @(negedge clk);
      chk(flag == 1'b0, "R7 flag cleared", int'(flag), 0);
      chk(irq == 1'b0, "R7 irq cleared", int'(irq), 0);
      chk(pwm == 4'b1111, "R7 outputs resume", int'(pwm), 15);

      // R8: manual recovery
      wr(ADR_FCTL, 3);
      @(negedge clk);
      fault_i = 1'b1;
      repeat (3) @(negedge clk);
      wr(ADR_FCTL, 7);
      chk(flag == 1'b1, "R8 clear ignored while fault high", int'(flag), 1);
      @(negedge clk);
      fault_i = 1'b0;
      repeat (20) @(negedge clk);
      chk(flag == 1'b1, "R8 flag held without clear", int'(flag), 1);
      chk(irq == 1'b1, "R8 irq held", int'(irq), 1);
      chk(pwm == 4'b0011, "R8 gate held without clear", int'(pwm), 3);
      wr(ADR_FCTL, 7);
      chk(flag == 1'b0, "R8 flag cleared by write", int'(flag), 0);
      chk(irq == 1'b0, "R8 irq cleared", int'(irq), 0);
      chk(pwm == 4'b0011, "R8 gate waits for boundary", int'(pwm), 3);
      repeat (5) @(negedge clk);
      chk(pwm == 4'b1111, "R8 outputs resume", int'(pwm), 15);

      finish_run();
   end

endmodule